// File: doc/BRIEF.md
# Buffer RAM Address Down-Counter

This block drives the 10-bit address of a 1024-byte buffer RAM that a processor reaches only through its I/O port space. The processor presets the address with byte-wide port writes. The low eight bits come from a dedicated preset port. The top two bits are taken from the two least significant data bits whenever a separate control port is written. Each completed RAM access then moves the address down by one. Because the step happens after the access, the next address is already settled well before the access that uses it.

A preset of N-1 makes the block raise an active-low overflow flag on the N-th access. The processor uses this flag to close a transfer loop of any length from 1 to 1024 bytes, such as 128-, 256- or 512-byte sector buffers. For scratchpad use, the processor presets an arbitrary address and then makes a single access. The block also decodes the access and write-enable strobes into a RAM read enable and a one-cycle write commit pulse.

All inputs are synchronous to the clock. An access is counted on the rising edge of the active-low access strobe.

Top module: `ram_addr_ctr`

## Requirements
- R1: Synchronous active-high reset sets the address to 1023 (all ones), deasserts the overflow flag (ovf_n = 1) and holds ram_wr_stb low.
- R2: A cycle with lo_wr high loads io_data[7:0] into address bits 7:0 and leaves bits 9:8 unchanged. The new value is visible after that clock edge.
- R3: A cycle with ctl_wr high loads io_data[1:0] into address bits 9:8 and leaves bits 7:0 unchanged. io_data[7:2] has no effect on the address.
- R4: Each low-to-high transition of acc_n, sampled at a clock edge, decrements the address by exactly one at that edge. The address holds while acc_n stays low or stays high.
- R5: A decrement borrows across internal counter sections, for example 0x100 becomes 0x0FF and 0x010 becomes 0x00F.
- R6: A decrement from address 0 wraps to 1023 and drives ovf_n low at the same edge.
- R7: ovf_n stays low through later decrements until a cycle with lo_wr or ctl_wr high, which returns it high.
- R8: If a preset write and an acc_n rising edge fall in the same cycle, the preset is applied and no decrement takes place.
- R9: After a preset to N-1, ovf_n stays high for the first N-1 accesses and goes low on the N-th access, for N of 128, 256, 512 and 1024.
- R10: ram_rd_en is high exactly while acc_n is low and we_n is high.
- R11: ram_wr_stb is high for one cycle when we_n goes from low to high while acc_n is low. A we_n rise while acc_n is high gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_data | input | 8 | Processor I/O data byte |
| lo_wr | input | 1 | Write strobe of the low-address preset port |
| ctl_wr | input | 1 | Write strobe of the control port (also loads address bits 9:8) |
| acc_n | input | 1 | Active-low RAM access strobe |
| we_n | input | 1 | Active-low RAM write enable |
| ram_addr | output | 10 | RAM address |
| ram_rd_en | output | 1 | RAM output enable for reads |
| ram_wr_stb | output | 1 | One-cycle RAM write commit pulse |
| ovf_n | output | 1 | Active-low end-of-loop overflow status |

## Verification
The bench builds the block with its default parameters: a 10-bit address, an 8-bit low preset field and 4-bit counter sections. This gives three sections of 4, 4 and 2 bits. Borrows therefore cross both section boundaries, including the one into the bits loaded through the control port. A full 1024-access loop also fits easily in the run, so the wrap and overflow path is tested at every sector length the requirements name, including the longest.

// File: rtl/ram_addr_pkg.sv
`timescale 1ns/1ps
package ram_addr_pkg;

    // Default geometry of the buffer address counter
    localparam int ADDR_W_DEF = 10;
    localparam int LOW_W_DEF  = 8;
    localparam int SECT_W_DEF = 4;
    localparam int DATA_W_DEF = 8;

    // Number of cascaded counter sections for a given address width
    function automatic int num_sections(input int addr_w, input int sect_w);
        return (addr_w + sect_w - 1) / sect_w;
    endfunction

    // Width of section idx (the last one may be narrower)
    function automatic int section_width(input int addr_w, input int sect_w, input int idx);
        int rem;
        rem = addr_w - idx * sect_w;
        return (rem < sect_w) ? rem : sect_w;
    endfunction

    // Decoded strobe events for one clock cycle
    typedef struct packed {
        logic dec;      // access completed: step address down
        logic rd_en;    // RAM read enable
        logic wr_stb;   // RAM write commit
    } strobe_ev_t;

    // Preset request for one clock cycle
    typedef struct packed {
        logic lo;       // low byte preset
        logic hi;       // upper bits preset via control port
    } preset_req_t;

endpackage

// File: rtl/ram_strobe_edge.sv
`timescale 1ns/1ps
module ram_strobe_edge
    import ram_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_n,
    input  logic       we_n,
    output strobe_ev_t ev
);

    logic acc_q;
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            acc_q <= acc_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        ev.dec    = acc_n & ~acc_q;
        ev.rd_en  = ~acc_n & we_n;
        ev.wr_stb = we_n & ~we_q & ~acc_n;
    end

    // A write commit never lasts two cycles
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ev.wr_stb |=> !ev.wr_stb);                                   // R11

    // Consecutive decrements need acc_n to go low in between
    AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ev.dec |=> !ev.dec);                                         // R4

endmodule

// File: rtl/ram_addr_section.sv
`timescale 1ns/1ps
module ram_addr_section #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset_any,
    input  logic [W-1:0] ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         borrow_in,
    output logic [W-1:0] q,
    output logic         borrow_out
);

    logic [W-1:0] q_nxt;

    always_comb begin
        q_nxt = q;
        if (preset_any) begin
            for (int b = 0; b < W; b++) begin
                if (ld_en[b]) q_nxt[b] = ld_val[b];
            end
        end else if (borrow_in) begin
            q_nxt = q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= q_nxt;
    end

    assign borrow_out = borrow_in & (q == '0);

    // Without preset or incoming borrow the section does not move
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!preset_any && !borrow_in) |=> $stable(q));                 // R4

    // A section at zero that receives a borrow wraps to all ones
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!preset_any && borrow_in && q == '0) |=> (q == '1));        // R5

endmodule

// File: rtl/ram_ovf_flag.sv
`timescale 1ns/1ps
module ram_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic preset_any,
    input  logic wrap,
    output logic ovf_n
);

    always_ff @(posedge clk) begin
        if (rst)             ovf_n <= 1'b1;
        else if (preset_any) ovf_n <= 1'b1;
        else if (wrap)       ovf_n <= 1'b0;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!ovf_n && !preset_any) |=> !ovf_n);                         // R7

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        preset_any |=> ovf_n);                                       // R7

endmodule

// File: rtl/ram_addr_ctr.sv
`timescale 1ns/1ps
module ram_addr_ctr
    import ram_addr_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LOW_W  = LOW_W_DEF,
    parameter int SECT_W = SECT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] io_data,
    input  logic              lo_wr,
    input  logic              ctl_wr,
    input  logic              acc_n,
    input  logic              we_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd_en,
    output logic              ram_wr_stb,
    output logic              ovf_n
);

    localparam int NSEC = num_sections(ADDR_W, SECT_W);

    strobe_ev_t        ev;
    preset_req_t       pre;
    logic              preset_any;
    logic [ADDR_W-1:0] ld_en;
    logic [ADDR_W-1:0] ld_val;
    logic [NSEC:0]     borrow;

    // Strobe decoding
    ram_strobe_edge u_strobe (
        .clk   (clk),
        .rst   (rst),
        .acc_n (acc_n),
        .we_n  (we_n),
        .ev    (ev)
    );

    assign pre.lo     = lo_wr;
    assign pre.hi     = ctl_wr;
    assign preset_any = pre.lo | pre.hi;

    // Per-bit preset source: low field from the preset port, upper from control port
    for (genvar b = 0; b < ADDR_W; b++) begin : gen_ld
        if (b < LOW_W) begin : g_lo
            assign ld_en[b]  = pre.lo;
            assign ld_val[b] = io_data[b];
        end else begin : g_hi
            assign ld_en[b]  = pre.hi;
            assign ld_val[b] = io_data[b-LOW_W];
        end
    end

    // Cascaded down-counter sections, borrow rippling upward
    assign borrow[0] = ev.dec;

    for (genvar s = 0; s < NSEC; s++) begin : gen_sec
        localparam int BASE = s * SECT_W;
        localparam int SW   = section_width(ADDR_W, SECT_W, s);

        ram_addr_section #(.W(SW)) u_sec (
            .clk        (clk),
            .rst        (rst),
            .preset_any (preset_any),
            .ld_en      (ld_en[BASE +: SW]),
            .ld_val     (ld_val[BASE +: SW]),
            .borrow_in  (borrow[s]),
            .q          (ram_addr[BASE +: SW]),
            .borrow_out (borrow[s+1])
        );
    end

    // End-of-loop status
    ram_ovf_flag u_ovf (
        .clk        (clk),
        .rst        (rst),
        .preset_any (preset_any),
        .wrap       (borrow[NSEC]),
        .ovf_n      (ovf_n)
    );

    assign ram_rd_en  = ev.rd_en;
    assign ram_wr_stb = ev.wr_stb;

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (ev.dec && !preset_any) |=> (ram_addr == $past(ram_addr) - ADDR_W'(1))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ev.dec && !preset_any) |=> $stable(ram_addr));             // R4

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ev.dec && !preset_any && ram_addr == '0) |=> (ram_addr == '1 && !ovf_n)); // R6

    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && !ctl_wr) |=> (ram_addr[ADDR_W-1:LOW_W] == $past(ram_addr[ADDR_W-1:LOW_W]))); // R8

    AST_RD_DECODE: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> (!acc_n && we_n));                             // R10

endmodule

// File: tb/ram_addr_ctr_bench.sv
`timescale 1ns/1ps
module ram_addr_ctr_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_data = 8'h00;
    logic       lo_wr = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       acc_n = 1'b1;
    logic       we_n = 1'b1;
    logic [9:0] ram_addr;
    logic       ram_rd_en;
    logic       ram_wr_stb;
    logic       ovf_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ram_addr_ctr u_ram_addr_ctr (
        .clk        (clk),
        .rst        (rst),
        .io_data    (io_data),
        .lo_wr      (lo_wr),
        .ctl_wr     (ctl_wr),
        .acc_n      (acc_n),
        .we_n       (we_n),
        .ram_addr   (ram_addr),
        .ram_rd_en  (ram_rd_en),
        .ram_wr_stb (ram_wr_stb),
        .ovf_n      (ovf_n)
    );

    // op: 0 low preset, 1 control write, 2 access, 3 idle
    // entry = {op[1:0], data[7:0], exp_addr[9:0], exp_ovf_n}
    localparam logic [20:0] VEC [13] = '{
        {2'd0, 8'h00, 10'h300, 1'b1},  // R2
        {2'd1, 8'h01, 10'h100, 1'b1},  // R3
        {2'd2, 8'h00, 10'h0FF, 1'b1},  // R5 borrow into top section
        {2'd2, 8'h00, 10'h0FE, 1'b1},  // R4
        {2'd0, 8'h10, 10'h010, 1'b1},  // R2
        {2'd2, 8'h00, 10'h00F, 1'b1},  // R5
        {2'd0, 8'h01, 10'h001, 1'b1},  // R2
        {2'd2, 8'h00, 10'h000, 1'b1},  // R4
        {2'd2, 8'h00, 10'h3FF, 1'b0},  // R6 wrap
        {2'd2, 8'h00, 10'h3FE, 1'b0},  // R7 stays low
        {2'd1, 8'h02, 10'h2FE, 1'b1},  // R3, R7 cleared
        {2'd1, 8'hFD, 10'h1FE, 1'b1},  // R3 upper data bits ignored
        {2'd3, 8'h00, 10'h1FE, 1'b1}   // R4 idle hold
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lo_write(input logic [7:0] d);
        io_data = d; lo_wr = 1'b1;
        tick();
        lo_wr = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] d);
        io_data = d; ctl_wr = 1'b1;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic access();
        acc_n = 1'b0;
        tick();
        acc_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk("R1 addr", int'(ram_addr), 'h3FF);
        chk("R1 ovf_n", int'(ovf_n), 1);
        chk("R1 wr_stb", int'(ram_wr_stb), 0);

        // Vector table
        for (int i = 0; i < 13; i++) begin
            logic [1:0] op;
            logic [7:0] d;
            op = VEC[i][20:19];
            d  = VEC[i][18:11];
            case (op)
                2'd0: lo_write(d);
                2'd1: ctl_write(d);
                2'd2: access();
                default: tick();
            endcase
            chk("R2/R3/R4/R5/R6/R7 table addr", int'(ram_addr), int'(VEC[i][10:1]));
            chk("R6/R7 table ovf_n", int'(ovf_n), int'(VEC[i][0]));
        end

        // R4: holding acc_n low does not step
        acc_n = 1'b0;
        repeat (3) tick();
        chk("R4 hold low", int'(ram_addr), 'h1FE);
        acc_n = 1'b1;
        tick();
        chk("R4 single step", int'(ram_addr), 'h1FD);
        repeat (3) tick();
        chk("R4 hold high", int'(ram_addr), 'h1FD);

        // R8: preset and access edge in the same cycle
        acc_n = 1'b0;
        tick();
        acc_n = 1'b1; io_data = 8'h55; lo_wr = 1'b1;
        tick();
        lo_wr = 1'b0;
        chk("R8 preset wins", int'(ram_addr), 'h155);
        tick();
        chk("R8 no late step", int'(ram_addr), 'h155);

        // R9: loop lengths
        foreach (VEC[k]) begin
            if (k < 4) begin
                int n;
                n = 128 << k;
                lo_write(8'((n - 1) & 'hFF));
                ctl_write(8'((n - 1) >> 8));
                chk("R9 preset", int'(ram_addr), n - 1);
                for (int a = 0; a < n - 1; a++) access();
                chk("R9 ovf before last", int'(ovf_n), 1);
                access();
                chk("R9 ovf on last", int'(ovf_n), 0);
                chk("R9 wrapped addr", int'(ram_addr), 'h3FF);
            end
        end

        // R10: read enable decode
        acc_n = 1'b0; we_n = 1'b1;
        #1;
        chk("R10 read", int'(ram_rd_en), 1);
        we_n = 1'b0;
        #1;
        chk("R10 write blocks read", int'(ram_rd_en), 0);
        acc_n = 1'b1; we_n = 1'b1;
        #1;
        chk("R10 idle", int'(ram_rd_en), 0);
        tick();

        // R11: write commit pulse
        acc_n = 1'b0; we_n = 1'b0;
        tick();
        we_n = 1'b1;
        #1;
        chk("R11 pulse", int'(ram_wr_stb), 1);
        tick();
        chk("R11 pulse ends", int'(ram_wr_stb), 0);
        acc_n = 1'b1;
        tick();
        we_n = 1'b0;
        tick();
        we_n = 1'b1;
        #1;
        chk("R11 no pulse without access", int'(ram_wr_stb), 0);
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule